// File: doc/BRIEF.md
# Serial Main-Array Read Sequencer

This block serves the two main-array read commands of a serial flash front end. The front end hands it one strobe per serial clock rising edge together with the sampled input bit, and a chip-select level. The sequencer decodes the 8-bit command, collects a 24-bit address, and counts off 32 priming bits. It then streams bytes from a page-organized array (4096 pages of 264 bytes), most significant bit first, one bit per strobe.

The array is reached through a synchronous read port whose data returns one clock after the request. The sequencer fetches the next byte while the current one is still shifting, so output bits follow each other with no pause at byte, page or array boundaries. One command runs across pages and wraps from the last page to the first. The other stays inside the starting page. Raising chip select ends either read at once and disables the output.

Top module: `array_read_seq`

## Requirements
- R1: Only command bytes 68h and E8h (run across pages) and 52h and D2h (stay in page) start a read. Any other command byte leaves `serOutEn` low and issues no array fetch until chip select is raised.
- R2: After the command come 24 address bits, most significant first: 3 ignored bits, then a 12-bit page number, then a 9-bit byte offset.
- R3: After the 64th strobe of a selection (8 command + 24 address + 32 priming bits), `serOutEn` is high and `serOut` carries bit 7 of the byte at the start address. Each later strobe moves on by one bit, MSB first, and outputs change only on a strobe.
- R4: In the run-across read, the byte after offset 263 is offset 0 of the next page, with no gap in the bit stream.
- R5: In the run-across read, the byte after page 4095 offset 263 is page 0 offset 0.
- R6: In the stay-in-page read, the byte after offset 263 is offset 0 of the same page.
- R7: A captured byte offset above 263 is reduced modulo 264 before the first fetch.
- R8: While chip select is high, strobes are ignored. From the clock after chip select is seen high, `serOutEn` is low. The next low period starts a new command.
- R9: Each fetch is a one-cycle `memRdEn` pulse with an offset below 264, and data is taken from `memRdData` one clock later. A read delivering N whole bytes issues exactly N+2 fetches.
- R10: During reset, `serOutEn` and `memRdEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select level, active low, synchronous to clk |
| bitValid | input | 1 | One-cycle strobe marking one serial clock rising edge |
| serIn | input | 1 | Serial input bit, valid with bitValid |
| serOut | output | 1 | Serial output data bit |
| serOutEn | output | 1 | Output drive enable; low means the pin is released |
| memRdEn | output | 1 | Array read request |
| memPage | output | 12 | Page number of the request |
| memByte | output | 9 | Byte offset of the request |
| memRdData | input | 8 | Array read data, one clock after memRdEn |

## Verification
On every cycle the checker confirms four things: outputs change only on a strobe, the output is released after chip select rises, every fetch offset is in range, and each fetch after the first in a read follows from its predecessor under the wrap rule of the latched command. That last check covers the page step, the last-page wrap and the in-page wrap. What no property can show is carried by the scenarios: that the streamed bytes equal the array contents at the right addresses, that the output starts at exactly the 64th strobe, that a bad command stays silent, that offsets above 263 are reduced, and that fetch counts match the bytes delivered.

// File: rtl/ars_pkg.sv
package ars_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } seqPhase_t;

  typedef struct packed {
    logic shiftIn;     // accept one serial input bit
    logic latchMode;   // command byte complete: record wrap rule
    logic captureAddr; // address complete: load page and offset
    logic fetch;       // issue one array read
    logic loadOut;     // move prefetched byte into output shifter
    logic shiftOut;    // advance output shifter by one bit
    logic clear;       // selection inactive
  } seqStrobe_t;

  function automatic logic opcIsRead(input logic [7:0] o);
    return (o == 8'h68) || (o == 8'hE8) || (o == 8'h52) || (o == 8'hD2);
  endfunction

  function automatic logic opcIsArray(input logic [7:0] o);
    return (o == 8'h68) || (o == 8'hE8);
  endfunction

endpackage

// File: rtl/ars_ctrl.sv
module ars_ctrl
  import ars_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       bitValid,
  input  logic [7:0] opcNext,
  output seqStrobe_t strb
);

  localparam int MAX_CNT = (ADDR_BITS > DUMMY_BITS) ? ADDR_BITS : DUMMY_BITS;
  localparam int CNT_W   = (MAX_CNT > 8) ? $clog2(MAX_CNT) : 3;
  localparam logic [CNT_W-1:0] LAST_OPC   = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR  = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W - 1);

  seqPhase_t        phase;
  logic [CNT_W-1:0] bitCnt;
  logic             fetchPend;
  logic             active;

  assign active = !csN && bitValid;

  always_comb begin
    strb       = '0;
    strb.clear = csN;
    strb.fetch = fetchPend && !csN;
    if (active) begin
      unique case (phase)
        PH_OPC: begin
          strb.shiftIn   = 1'b1;
          strb.latchMode = (bitCnt == LAST_OPC) && opcIsRead(opcNext);
        end
        PH_ADDR: begin
          strb.shiftIn     = 1'b1;
          strb.captureAddr = (bitCnt == LAST_ADDR);
        end
        PH_DUMMY: strb.loadOut = (bitCnt == LAST_DUMMY);
        PH_DATA: begin
          strb.loadOut  = (bitCnt == LAST_DATA);
          strb.shiftOut = (bitCnt != LAST_DATA);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_OPC;
      bitCnt    <= '0;
      fetchPend <= 1'b0;
    end else if (csN) begin
      phase     <= PH_OPC;
      bitCnt    <= '0;
      fetchPend <= 1'b0;
    end else begin
      if (strb.captureAddr || strb.loadOut) fetchPend <= 1'b1;
      else if (strb.fetch)                  fetchPend <= 1'b0;

      if (active) begin
        unique case (phase)
          PH_OPC: begin
            if (bitCnt == LAST_OPC) begin
              phase  <= opcIsRead(opcNext) ? PH_ADDR : PH_SKIP;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_ADDR: begin
            if (bitCnt == LAST_ADDR) begin
              phase  <= PH_DUMMY;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DUMMY: begin
            if (bitCnt == LAST_DUMMY) begin
              phase  <= PH_DATA;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (bitCnt == LAST_DATA) bitCnt <= '0;
            else                     bitCnt <= bitCnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ars_datapath.sv
module ars_datapath
  import ars_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 9,
  parameter int PAGE_BYTES = 264,
  parameter int NUM_PAGES  = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] memRdData,
  output logic [7:0]        opcNext,
  output logic              memRdEn,
  output logic [PAGE_W-1:0] memPage,
  output logic [BYTE_W-1:0] memByte,
  output logic              serOut,
  output logic              serOutEn,
  output logic              isArray
);

  localparam int SR_W = PAGE_W + BYTE_W - 1;
  localparam logic [BYTE_W-1:0] BYTES_C   = BYTE_W'(PAGE_BYTES);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic [SR_W-1:0]   inSr;
  logic [BYTE_W-1:0] rawByte;
  logic [BYTE_W-1:0] clampByte;
  logic [PAGE_W-1:0] rawPage;
  logic [PAGE_W-1:0] curPage, nextPage;
  logic [BYTE_W-1:0] curByte, nextByte;
  logic              atPageEnd;
  logic              rdPending;
  logic [DATA_W-1:0] prefetch;
  logic [DATA_W-1:0] outSr;
  logic              outValid;

  // incoming-bit view used at the edge that completes a field
  assign opcNext   = {inSr[6:0], serIn};
  assign rawByte   = {inSr[BYTE_W-2:0], serIn};
  assign rawPage   = inSr[BYTE_W-1 +: PAGE_W];
  assign clampByte = (rawByte >= BYTES_C) ? (rawByte - BYTES_C) : rawByte;

  // successor address under the latched wrap rule
  assign atPageEnd = (curByte == LAST_BYTE);
  always_comb begin
    nextByte = atPageEnd ? '0 : curByte + 1'b1;
    nextPage = curPage;
    if (atPageEnd && isArray)
      nextPage = (curPage == LAST_PAGE) ? '0 : curPage + 1'b1;
  end

  assign memRdEn  = strb.fetch;
  assign memPage  = curPage;
  assign memByte  = curByte;
  assign serOut   = outSr[DATA_W-1];
  assign serOutEn = outValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSr    <= '0;
      isArray <= 1'b0;
      curPage <= '0;
      curByte <= '0;
    end else begin
      if (strb.shiftIn)   inSr    <= {inSr[SR_W-2:0], serIn};
      if (strb.latchMode) isArray <= opcIsArray(opcNext);
      if (strb.captureAddr) begin
        curPage <= rawPage;
        curByte <= clampByte;
      end else if (strb.fetch) begin
        curPage <= nextPage;
        curByte <= nextByte;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPending <= 1'b0;
      prefetch  <= '0;
    end else begin
      rdPending <= strb.fetch;
      if (rdPending) prefetch <= memRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSr    <= '0;
      outValid <= 1'b0;
    end else if (strb.clear) begin
      outSr    <= '0;
      outValid <= 1'b0;
    end else if (strb.loadOut) begin
      outSr    <= prefetch;
      outValid <= 1'b1;
    end else if (strb.shiftOut) begin
      outSr    <= {outSr[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/array_read_seq.sv
module array_read_seq
  import ars_pkg::*;
#(
  parameter int RSV_W      = 3,
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 9,
  parameter int PAGE_BYTES = 264,
  parameter int NUM_PAGES  = 4096,
  parameter int DUMMY_BITS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              bitValid,
  input  logic              serIn,
  output logic              serOut,
  output logic              serOutEn,
  output logic              memRdEn,
  output logic [PAGE_W-1:0] memPage,
  output logic [BYTE_W-1:0] memByte,
  input  logic [DATA_W-1:0] memRdData
);

  localparam int ADDR_BITS = RSV_W + PAGE_W + BYTE_W;

  seqStrobe_t strb;
  logic [7:0] opcNext;
  logic       modeArray;

  ars_ctrl #(
    .ADDR_BITS (ADDR_BITS),
    .DUMMY_BITS(DUMMY_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .bitValid(bitValid),
    .opcNext (opcNext),
    .strb    (strb)
  );

  ars_datapath #(
    .PAGE_W    (PAGE_W),
    .BYTE_W    (BYTE_W),
    .PAGE_BYTES(PAGE_BYTES),
    .NUM_PAGES (NUM_PAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .serIn    (serIn),
    .strb     (strb),
    .memRdData(memRdData),
    .opcNext  (opcNext),
    .memRdEn  (memRdEn),
    .memPage  (memPage),
    .memByte  (memByte),
    .serOut   (serOut),
    .serOutEn (serOutEn),
    .isArray  (modeArray)
  );

endmodule

// File: rtl/ars_chk.sv
module ars_chk #(
  parameter int PAGE_W     = 12,
  parameter int BYTE_W     = 9,
  parameter int PAGE_BYTES = 264,
  parameter int NUM_PAGES  = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              bitValid,
  input logic              serOut,
  input logic              serOutEn,
  input logic              memRdEn,
  input logic [PAGE_W-1:0] memPage,
  input logic [BYTE_W-1:0] memByte,
  input logic              isArray
);

  localparam logic [BYTE_W-1:0] BYTES_C   = BYTE_W'(PAGE_BYTES);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic              haveLast;
  logic [PAGE_W-1:0] lastPage, expPage;
  logic [BYTE_W-1:0] lastByte, expByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastPage <= '0;
      lastByte <= '0;
    end else if (csN) begin
      haveLast <= 1'b0;
    end else if (memRdEn) begin
      haveLast <= 1'b1;
      lastPage <= memPage;
      lastByte <= memByte;
    end
  end

  always_comb begin
    expByte = (lastByte == LAST_BYTE) ? '0 : lastByte + 1'b1;
    expPage = lastPage;
    if ((lastByte == LAST_BYTE) && isArray)
      expPage = (lastPage == LAST_PAGE) ? '0 : lastPage + 1'b1;
  end

  // R4, R5, R6: consecutive fetches follow the wrap rule of the command
  assert_fetch_seq_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && haveLast) |-> (memByte == expByte && memPage == expPage));

  assert_byte_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (memByte < BYTES_C));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !serOutEn);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !bitValid) |=> ($stable(serOut) && $stable(serOutEn)));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serOutEn) |-> ($past(bitValid) && !$past(csN)));

endmodule

bind array_read_seq ars_chk #(
  .PAGE_W    (PAGE_W),
  .BYTE_W    (BYTE_W),
  .PAGE_BYTES(PAGE_BYTES),
  .NUM_PAGES (NUM_PAGES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .bitValid(bitValid),
  .serOut  (serOut),
  .serOutEn(serOutEn),
  .memRdEn (memRdEn),
  .memPage (memPage),
  .memByte (memByte),
  .isArray (modeArray)
);

// File: tb/tb_array_read_seq.sv
module tb_array_read_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        bitValid = 1'b0;
  logic        serIn = 1'b0;
  logic        serOut, serOutEn, memRdEn;
  logic [11:0] memPage;
  logic [8:0]  memByte;
  logic [7:0]  memRdData = 8'h00;

  int nChecks = 0;
  int nFail   = 0;
  int fetchCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  array_read_seq dut (
    .clk(clk), .rstN(rstN), .csN(csN), .bitValid(bitValid), .serIn(serIn),
    .serOut(serOut), .serOutEn(serOutEn), .memRdEn(memRdEn),
    .memPage(memPage), .memByte(memByte), .memRdData(memRdData)
  );

  function automatic logic [7:0] memVal(input int p, input int b);
    return 8'((p * 37) ^ (b * 11) ^ (p >> 4) ^ (b >> 3));
  endfunction

  always_ff @(posedge clk) begin
    if (memRdEn) memRdData <= memVal(int'(memPage), int'(memByte));
    if (memRdEn) fetchCnt <= fetchCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic b);
    @(negedge clk);
    serIn = b;
    bitValid = 1'b1;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic startRead(input logic [7:0] opc, input logic [2:0] rsv,
                           input int page, input int offs);
    logic [23:0] a;
    a = {rsv, 12'(page), 9'(offs)};
    @(negedge clk);
    csN = 1'b0;
    fetchCnt = 0;
    for (int i = 7; i >= 0; i--) strobe(opc[i]);
    for (int i = 23; i >= 0; i--) strobe(a[i]);
    for (int i = 0; i < 32; i++) strobe(1'($urandom));
  endtask

  task automatic endRead();
    @(negedge clk);
    csN = 1'b1;
    @(negedge clk);
    check(serOutEn == 1'b0, "R8 release", int'(serOutEn), 0);
  endtask

  function automatic int clampB(input int b);
    return (b >= 264) ? b - 264 : b;
  endfunction

  task automatic stepAddr(inout int p, inout int b, input bit arr);
    if (b == 263) begin
      b = 0;
      if (arr) p = (p + 1) % 4096;
    end else begin
      b = b + 1;
    end
  endtask

  task automatic readAndCheck(input logic [7:0] opc, input int page, input int offs,
                              input int nBytes, input string req);
    int p, b;
    logic [7:0] got, exp;
    bit arr;
    arr = (opc == 8'h68) || (opc == 8'hE8);
    p = page;
    b = clampB(offs);
    for (int k = 0; k < nBytes; k++) begin
      exp = memVal(p, b);
      for (int j = 7; j >= 0; j--) begin
        got[j] = serOut;
        if (j == 7)
          check(serOutEn == 1'b1, "R3 enable", int'(serOutEn), 1);
        strobe(1'($urandom));
      end
      check(got == exp, req, int'(got), int'(exp));
      stepAddr(p, b, arr);
    end
    @(negedge clk);
    @(negedge clk);
    check(fetchCnt == nBytes + 2, "R9 fetch count", fetchCnt, nBytes + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] opcs [4];
    void'($urandom(32'h5eed_1234));
    opcs[0] = 8'h68; opcs[1] = 8'hE8; opcs[2] = 8'h52; opcs[3] = 8'hD2;

    repeat (3) @(negedge clk);
    check(serOutEn == 1'b0 && memRdEn == 1'b0, "R10 reset", int'({serOutEn, memRdEn}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(serOutEn == 1'b0, "R10 after reset", int'(serOutEn), 0);

    // R3 + R4: start near page end, cross into next page
    startRead(8'h68, 3'b000, 5, 258);
    readAndCheck(8'h68, 5, 258, 12, "R4 page step");
    endRead();

    // R5: last page wraps to page 0
    startRead(8'hE8, 3'b101, 4095, 262);
    readAndCheck(8'hE8, 4095, 262, 6, "R5 array wrap");
    endRead();

    // R6: stay-in-page wrap
    startRead(8'h52, 3'b000, 100, 260);
    readAndCheck(8'h52, 100, 260, 10, "R6 page wrap");
    endRead();

    // R7: offsets above 263 reduced
    startRead(8'hD2, 3'b000, 77, 300);
    readAndCheck(8'hD2, 77, 300, 3, "R7 clamp 300");
    endRead();
    startRead(8'h68, 3'b111, 4095, 511);
    readAndCheck(8'h68, 4095, 511, 20, "R7 clamp 511");
    endRead();

    // R1: unsupported command stays silent
    startRead(8'h54, 3'b000, 9, 9);
    for (int i = 0; i < 16; i++) strobe(1'b1);
    check(serOutEn == 1'b0, "R1 bad opcode enable", int'(serOutEn), 0);
    check(fetchCnt == 0, "R1 bad opcode fetches", fetchCnt, 0);
    endRead();

    // R8: mid-read termination, ignored strobes, fresh read after
    startRead(8'h68, 3'b000, 33, 40);
    readAndCheck(8'h68, 33, 40, 2, "R3 before stop");
    strobe(1'b0); strobe(1'b1); strobe(1'b0);
    endRead();
    fetchCnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); serIn = 1'b1; bitValid = 1'b1;
      @(negedge clk); bitValid = 1'b0;
    end
    check(serOutEn == 1'b0 && fetchCnt == 0, "R8 ignored strobes", fetchCnt, 0);
    startRead(8'h52, 3'b000, 1234, 5);
    readAndCheck(8'h52, 1234, 5, 2, "R8 new read");
    endRead();

    // R2: random reads with random reserved bits
    for (int t = 0; t < 24; t++) begin
      logic [7:0] o;
      int pg, of, nb;
      o  = opcs[$urandom_range(3, 0)];
      pg = $urandom_range(4095, 0);
      of = $urandom_range(511, 0);
      if (t % 4 == 0) of = $urandom_range(263, 250);
      nb = $urandom_range(16, 1);
      startRead(o, 3'($urandom), pg, of);
      readAndCheck(o, pg, of, nb, "R2 random read");
      endRead();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule